// File: doc/BRIEF.md
# Dual-Port RAM with Write-Port Readback

This block is a synchronous RAM on one clock with one write port and one read port. The write port takes an enable, an address and a data word. It also returns a registered copy of the word at its own address. When a write happens, that copy is the word just written. When no write happens, it is the stored word. The read port takes an address and returns the registered stored word one clock later.

When both ports name the same address in a cycle that writes, the two ports resolve the collision in opposite ways. The write port returns the new word. The read port returns the word that was stored before the write. Neither the storage nor the output registers have a reset, so synthesis can map the array onto block memory. Data width and address width are parameters, and the depth is two to the power of the address width.

Top module: `dpram_wr_readback`

## Requirements
- R1: Both data outputs are registered. A change on an address input reaches the matching output only after the next rising clock edge, and the output holds its value until then.
- R2: In a cycle with `wr_en_i` high, the word on `wr_data_i` is stored at `wr_addr_i`, and `wr_data_o` shows that same word after the next edge (write-first on the write port).
- R3: In a cycle that writes address A while `rd_addr_i` also equals A, `rd_data_o` shows the word held at A before that write (read-first across the ports).
- R4: In a cycle with `wr_en_i` low, `wr_data_o` shows the stored word at `wr_addr_i` after the next edge, and the word on `wr_data_i` is not stored anywhere.
- R5: `rd_data_o` shows the stored word at `rd_addr_i` after the next edge, including a word written in the previous cycle.
- R6: `AW` (2 to 29, default 8) sets the address width and `DW` (default 16) sets the data width. The lowest address (0) and the highest address (2**AW-1) both hold independent words.
- R7: A write changes only the addressed location. All other locations keep their words.
- R8: A run of back-to-back writes to one address, while the read port reads that address, makes `rd_data_o` lag one write behind. `wr_data_o` shows the latest word each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| wr_en_i | input | 1 | Write enable, active high |
| wr_addr_i | input | AW | Write-port address |
| wr_data_i | input | DW | Word to store |
| wr_data_o | output | DW | Registered word at the write address (new word when writing) |
| rd_addr_i | input | AW | Read-port address |
| rd_data_o | output | DW | Registered stored word at the read address |

## Verification
A sequential fill, with the read port trailing one address behind the write port, shows that a word written in one cycle is visible to a read in the next. A pass with the enable low and junk on the data input separates the write port's readback path from its storage path. Single-cycle collisions and a run of back-to-back writes to one address while reading it separate the read-first rule from the write-first rule. Probes at address 0 and at the top address, and a probe of the output between edges, confirm the full address range and the one-cycle registering.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned AW_MIN = 2;
  localparam int unsigned AW_MAX = 29;

  // Collision policy for an output port register
  typedef enum logic {
    POL_READ_FIRST  = 1'b0,
    POL_WRITE_FIRST = 1'b1
  } port_pol_e;
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] wa_word_o,
  output logic [DW-1:0] ra_word_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // No reset: keeps the array inferable as block memory
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  // Pre-write contents; the port registers pick the collision policy
  assign wa_word_o = mem_q[wa_i];
  assign ra_word_o = mem_q[ra_i];
endmodule

// File: rtl/dpram_port_reg.sv
module dpram_port_reg
  import dpram_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter port_pol_e   POLICY = POL_READ_FIRST
) (
  input  logic          clk_i,
  input  logic          hit_i,
  input  logic [DW-1:0] new_i,
  input  logic [DW-1:0] old_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] next_d;

  generate
    if (POLICY == POL_WRITE_FIRST) begin : g_wf
      assign next_d = hit_i ? new_i : old_i;
    end else begin : g_rf
      logic unused_w;
      assign unused_w = hit_i ^ (^new_i);
      assign next_d   = old_i;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    data_o <= next_d;
  end
endmodule

// File: rtl/dpram_wr_readback.sv
module dpram_wr_readback
  import dpram_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] wr_data_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  generate
    if (AW < AW_MIN || AW > AW_MAX) begin : g_bad_aw
      $error("dpram_wr_readback: AW out of range");
    end
  endgenerate

  logic [DW-1:0] wa_word;
  logic [DW-1:0] ra_word;
  logic          rd_hit;

  assign rd_hit = wr_en_i && (rd_addr_i == wr_addr_i);

  dpram_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .we_i      (wr_en_i),
    .wa_i      (wr_addr_i),
    .wd_i      (wr_data_i),
    .ra_i      (rd_addr_i),
    .wa_word_o (wa_word),
    .ra_word_o (ra_word)
  );

  dpram_port_reg #(.DW(DW), .POLICY(POL_WRITE_FIRST)) u_wr_port (
    .clk_i  (clk_i),
    .hit_i  (wr_en_i),
    .new_i  (wr_data_i),
    .old_i  (wa_word),
    .data_o (wr_data_o)
  );

  dpram_port_reg #(.DW(DW), .POLICY(POL_READ_FIRST)) u_rd_port (
    .clk_i  (clk_i),
    .hit_i  (rd_hit),
    .new_i  (wr_data_i),
    .old_i  (ra_word),
    .data_o (rd_data_o)
  );
endmodule

// File: rtl/dpram_wr_readback_chk.sv
module dpram_wr_readback_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [DW-1:0] wr_data_o,
  input logic [AW-1:0] rd_addr_i,
  input logic [DW-1:0] rd_data_o
);
  // RAM has no reset; hold checks off until enough history exists
  logic [1:0] warm_q;
  logic       warm_ok;
  initial warm_q = 2'd0;
  always @(posedge clk_i) begin
    if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end
  assign warm_ok = (warm_q == 2'd3);

  p_wr_first_r2: assert property (@(posedge clk_i) disable iff (!warm_ok)
    wr_en_i |=> (wr_data_o == $past(wr_data_i)));

  p_read_first_r3: assert property (@(posedge clk_i) disable iff (!warm_ok)
    (wr_en_i && rd_addr_i == wr_addr_i && $past(wr_en_i) && $past(wr_addr_i) == wr_addr_i)
    |=> (rd_data_o == $past(wr_data_i, 2)));

  p_idle_readback_r4: assert property (@(posedge clk_i) disable iff (!warm_ok)
    (!wr_en_i && $past(wr_en_i) && $past(wr_addr_i) == wr_addr_i)
    |=> (wr_data_o == $past(wr_data_i, 2)));

  p_read_after_write_r5: assert property (@(posedge clk_i) disable iff (!warm_ok)
    ($past(wr_en_i) && rd_addr_i == $past(wr_addr_i))
    |=> (rd_data_o == $past(wr_data_i, 2)));

  p_ports_agree_r1: assert property (@(posedge clk_i) disable iff (!warm_ok)
    (!wr_en_i && rd_addr_i == wr_addr_i) |=> (rd_data_o == wr_data_o));
endmodule

bind dpram_wr_readback dpram_wr_readback_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .wr_data_o (wr_data_o),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/dpram_wr_readback_bench.sv
module dpram_wr_readback_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] wr_data_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  bit            known   [DEPTH];

  always #5 clk_i = ~clk_i;

  dpram_wr_readback #(.AW(AW), .DW(DW)) u_dpram_wr_readback (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_data_o (wr_data_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One clock with model update; checks outputs of locations already written
  task automatic cyc(input logic wen, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic [AW-1:0] ra, input string req);
    logic [DW-1:0] exp_rd, exp_wr;
    bit rd_ok, wr_ok;
    @(negedge clk_i);
    wr_en_i = wen; wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
    exp_rd = ref_mem[ra];
    rd_ok  = known[ra];
    exp_wr = wen ? wd : ref_mem[wa];
    wr_ok  = wen || known[wa];
    if (wen) begin
      ref_mem[wa] = wd;
      known[wa]   = 1'b1;
    end
    @(posedge clk_i);
    #1;
    if (rd_ok) check(req, "rd_data_o", rd_data_o, exp_rd);
    if (wr_ok) check(req, "wr_data_o", wr_data_o, exp_wr);
  endtask

  // R2 R5: sequential fill, read trails write by one address
  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, AW'(i + 8), DW'(16'h1000 + i * 16'h0111), AW'(i + 7), "R5");
    end
  endtask

  // R4: enable low, junk on data bus, then confirm storage untouched
  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, AW'(i + 8), 16'hDEAD, AW'(i + 16), "R4");
    end
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, AW'(i + 16), 16'hBEEF, AW'(i + 8), "R4");
    end
  endtask

  // R3: single-cycle collision, then a plain read of the new value
  task automatic t_collide();
    cyc(1'b1, AW'(10), 16'hC0DE, AW'(10), "R3");
    cyc(1'b1, AW'(12), 16'h5A5A, AW'(12), "R3");
    cyc(1'b0, AW'(10), 16'h0000, AW'(12), "R3");
  endtask

  // R8: back-to-back writes to one address while reading it
  task automatic t_burst();
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, AW'(20), DW'(16'hA000 + i), AW'(20), "R8");
    end
    cyc(1'b0, AW'(20), 16'hFFFF, AW'(20), "R8");
  endtask

  // R7: neighbours of a written address keep their words
  task automatic t_isolate();
    cyc(1'b1, AW'(13), 16'h7777, AW'(14), "R7");
    cyc(1'b0, AW'(14), 16'h0000, AW'(15), "R7");
    cyc(1'b0, AW'(12), 16'h0000, AW'(13), "R7");
  endtask

  // R6: lowest and highest addresses are distinct locations
  task automatic t_edges();
    cyc(1'b1, AW'(0), 16'h0F0F, AW'(8), "R6");
    cyc(1'b1, AW'(DEPTH - 1), 16'hF0F0, AW'(0), "R6");
    cyc(1'b0, AW'(0), 16'h0000, AW'(DEPTH - 1), "R6");
    cyc(1'b0, AW'(DEPTH - 1), 16'h0000, AW'(0), "R6");
  endtask

  // R1: outputs hold between edges after address changes
  task automatic t_latency();
    logic [DW-1:0] old_rd, old_wr;
    cyc(1'b0, AW'(9), 16'h0000, AW'(8), "R1");
    old_rd = rd_data_o;
    old_wr = wr_data_o;
    @(negedge clk_i);
    rd_addr_i = AW'(DEPTH - 1);
    wr_addr_i = AW'(0);
    #2;
    check("R1", "rd_data_o held", rd_data_o, old_rd);
    check("R1", "wr_data_o held", wr_data_o, old_wr);
    @(posedge clk_i);
    #1;
    check("R1", "rd_data_o after edge", rd_data_o, ref_mem[DEPTH - 1]);
    check("R1", "wr_data_o after edge", wr_data_o, ref_mem[0]);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      known[i]   = 1'b0;
      ref_mem[i] = '0;
    end
    repeat (3) @(posedge clk_i);
    t_fill();
    t_idle();
    t_collide();
    t_burst();
    t_isolate();
    t_edges();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule